// File: doc/BRIEF.md
# RF Level Sample Statistics Engine

This block turns a stream of 10-bit readings from a logarithmic RF detector's ADC into one level figure per request. It has its own sample pacing timer. While a measurement runs, the timer divides the system clock by a programmable count and issues a one-cycle sample strobe. The ADC value present at each strobe is consumed.

A host picks one of five statistics with a mode code and a start pulse:
- one sample;
- the truncated mean of 128 samples;
- the truncated mean of 1024 samples;
- the largest of 1024 consecutive samples;
- the smallest of 1024 consecutive samples.

The 1024-sample window is sized for the host's sample interval to span several periods of a slow amplitude-modulated envelope, so that peak and trough capture see its extremes. The answer is held on a result port with a done flag until the next accepted start.

Top module: `lvlstat_engine`

## Requirements
- R1: After reset, `res_done`, `busy`, `sample_strobe` and `res_value` are all 0.
- R2: While busy, `sample_strobe` pulses for one cycle every `div_count`+1 clocks. The first pulse falls `div_count`+1 clocks after the edge that accepted the start. `div_count` is captured at that edge, and later changes do not affect the running measurement.
- R3: Mode codes on `cmd_mode` are 0 single, 1 mean of 128, 2 mean of 1024, 3 maximum over 1024 and 4 minimum over 1024. A start with code 5, 6 or 7 is not accepted: `busy` stays 0 and `res_done` keeps its value.
- R4: In mode 0 the result is the sample present at the first strobe.
- R5: In modes 1 and 2 the result is the sum of the first 128 or 1024 strobed samples shifted right by 7 or 10 bits, with the remainder discarded.
- R6: In mode 3 the result is the largest of 1024 strobed samples.
- R7: In mode 4 the result is the smallest of 1024 strobed samples. The tracker is seeded from the first sample, so a window with every sample at 1023 returns 1023.
- R8: A start pulse that arrives while `busy` is 1 is ignored. The running measurement's result and its completion time are unchanged.
- R9: An accepted start clears `res_done` and raises `busy` on the next edge. `res_done` and `res_value` then hold until the next accepted start.
- R10: `res_done` rises N*(`div_count`+1)+1 clock edges after the edge that accepted the start, where N is the mode's sample count. `busy` falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_count | input | 16 | Sample interval minus one, in clocks |
| cmd_start | input | 1 | Start request pulse |
| cmd_mode | input | 3 | Measurement mode code |
| adc_sample | input | 10 | Detector ADC reading |
| sample_strobe | output | 1 | One-cycle pulse marking each sample taken |
| busy | output | 1 | Measurement in progress |
| res_value | output | 10 | Measurement result |
| res_done | output | 1 | Result valid, held until next accepted start |

## Verification
The bench builds the engine with its default parameters: 10-bit samples, 16-bit divider, and window shifts of 7 and 10. Full 1024-sample windows therefore run with the true truncation arithmetic, and the accumulator's top bits are exercised by an all-1023 window. Small divider values of 0 to 3 keep each window near one to four thousand clocks. This allows every mode to be exercised with several sample patterns, including:
- a ramp whose exact mean has a fractional half;
- a single spike or dip placed at the window's end.

The completion edge count is checked against the interval formula for each of these runs.

// File: rtl/lvlstat_pkg.sv
package lvlstat_pkg;

   typedef enum logic [2:0] {
      MODE_SINGLE  = 3'd0,
      MODE_AVG_S   = 3'd1,
      MODE_AVG_L   = 3'd2,
      MODE_PEAK    = 3'd3,
      MODE_TROUGH  = 3'd4
   } lvl_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } lvl_state_e;

   function automatic logic mode_legal(input logic [2:0] m);
      return (m <= 3'd4);
   endfunction

endpackage

// File: rtl/lvlstat_pacer.sv
module lvlstat_pacer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         div_q <= div_in;
         cnt_q <= '0;
      end else if (run) begin
         if (cnt_q == div_q) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == div_q);

endmodule

// File: rtl/lvlstat_accum.sv
module lvlstat_accum #(
   parameter int SAMPLE_W = 10,
   parameter int ACC_W    = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                add,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [ACC_W-1:0]    acc
);

   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else if (add)   acc_q <= acc_q + ACC_W'(sample);
   end

   assign acc = acc_q;

endmodule

// File: rtl/lvlstat_extreme.sv
module lvlstat_extreme #(
   parameter int SAMPLE_W = 10,
   parameter bit FIND_MAX = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                add,
   input  logic                first,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [SAMPLE_W-1:0] ext
);

   logic [SAMPLE_W-1:0] ext_q;
   logic                better;

   generate
      if (FIND_MAX) begin : g_max
         assign better = (sample > ext_q);
      end else begin : g_min
         assign better = (sample < ext_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                   ext_q <= '0;
      else if (add && (first || better)) ext_q <= sample;
   end

   assign ext = ext_q;

endmodule

// File: rtl/lvlstat_ctrl.sv
module lvlstat_ctrl
   import lvlstat_pkg::*;
#(
   parameter int SHORT_LOG2 = 7,
   parameter int LONG_LOG2  = 10,
   localparam int CNT_W     = LONG_LOG2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_start,
   input  logic [2:0] cmd_mode,
   input  logic       tick,
   output logic       accept,
   output logic       running,
   output logic       finishing,
   output logic       first_smp,
   output lvl_mode_e  mode_q
);

   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_LOG2) - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = '1;

   lvl_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;

   assign accept = (state_q == ST_IDLE) && cmd_start && mode_legal(cmd_mode);

   always_comb begin
      case (mode_q)
         MODE_SINGLE: target = '0;
         MODE_AVG_S:  target = SHORT_LAST;
         default:     target = LONG_LAST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_SINGLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_RUN;
                  mode_q  <= lvl_mode_e'(cmd_mode);
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == target) state_q <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign running   = (state_q == ST_RUN);
   assign finishing = (state_q == ST_FIN);
   assign first_smp = (cnt_q == '0);

endmodule

// File: rtl/lvlstat_engine.sv
module lvlstat_engine
   import lvlstat_pkg::*;
#(
   parameter int SAMPLE_W   = 10,
   parameter int DIV_W      = 16,
   parameter int SHORT_LOG2 = 7,
   parameter int LONG_LOG2  = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    div_count,
   input  logic                cmd_start,
   input  logic [2:0]          cmd_mode,
   input  logic [SAMPLE_W-1:0] adc_sample,
   output logic                sample_strobe,
   output logic                busy,
   output logic [SAMPLE_W-1:0] res_value,
   output logic                res_done
);

   localparam int ACC_W = SAMPLE_W + LONG_LOG2;

   generate
      if (SAMPLE_W < 1) begin : g_bad_w
         $error("SAMPLE_W must be positive");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be positive");
      end
      if (SHORT_LOG2 < 1 || LONG_LOG2 <= SHORT_LOG2) begin : g_bad_win
         $error("window shifts must satisfy 0 < SHORT_LOG2 < LONG_LOG2");
      end
   endgenerate

   logic            accept;
   logic            running;
   logic            finishing;
   logic            first_smp;
   lvl_mode_e       mode_q;
   logic            tick;
   logic [ACC_W-1:0] acc;
   logic [SAMPLE_W-1:0] ext_val [2];
   logic [SAMPLE_W-1:0] peak_val;
   logic [SAMPLE_W-1:0] trough_val;
   logic [SAMPLE_W-1:0] sel_val;
   logic [SAMPLE_W-1:0] res_q;
   logic                done_q;

   lvlstat_ctrl #(
      .SHORT_LOG2 (SHORT_LOG2),
      .LONG_LOG2  (LONG_LOG2)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_mode  (cmd_mode),
      .tick      (tick),
      .accept    (accept),
      .running   (running),
      .finishing (finishing),
      .first_smp (first_smp),
      .mode_q    (mode_q)
   );

   lvlstat_pacer #(.DIV_W(DIV_W)) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .run    (running),
      .div_in (div_count),
      .tick   (tick)
   );

   lvlstat_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .add    (tick),
      .sample (adc_sample),
      .acc    (acc)
   );

   generate
      for (genvar g = 0; g < 2; g++) begin : g_ext
         lvlstat_extreme #(
            .SAMPLE_W (SAMPLE_W),
            .FIND_MAX (g == 0)
         ) u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .add    (tick),
            .first  (first_smp),
            .sample (adc_sample),
            .ext    (ext_val[g])
         );
      end
   endgenerate

   assign peak_val   = ext_val[0];
   assign trough_val = ext_val[1];

   always_comb begin
      case (mode_q)
         MODE_SINGLE: sel_val = acc[SAMPLE_W-1:0];
         MODE_AVG_S:  sel_val = acc[SHORT_LOG2 +: SAMPLE_W];
         MODE_AVG_L:  sel_val = acc[LONG_LOG2 +: SAMPLE_W];
         MODE_PEAK:   sel_val = peak_val;
         MODE_TROUGH: sel_val = trough_val;
         default:     sel_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else if (accept) begin
         done_q <= 1'b0;
      end else if (finishing) begin
         done_q <= 1'b1;
         res_q  <= sel_val;
      end
   end

   assign sample_strobe = tick;
   assign busy          = running | finishing;
   assign res_value     = res_q;
   assign res_done      = done_q;

endmodule

// File: rtl/lvlstat_engine_chk.sv
module lvlstat_engine_chk #(
   parameter int SAMPLE_W = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_start,
   input logic [2:0]          cmd_mode,
   input logic                sample_strobe,
   input logic                busy,
   input logic                res_done,
   input logic [SAMPLE_W-1:0] res_value,
   input logic [SAMPLE_W-1:0] peak_val,
   input logic [SAMPLE_W-1:0] trough_val,
   input logic [2:0]          mode_q
);

   p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> busy);

   p_bad_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy && cmd_mode > 3'd4) |=> (!busy && res_done == $past(res_done)));

   p_order_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
      peak_val >= trough_val);

   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_start) |=> $stable(mode_q));

   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy && cmd_mode <= 3'd4) |=> (busy && !res_done));

   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && !cmd_start) |=> (res_done && $stable(res_value)));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> !busy);

endmodule

bind lvlstat_engine lvlstat_engine_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_start     (cmd_start),
   .cmd_mode      (cmd_mode),
   .sample_strobe (sample_strobe),
   .busy          (busy),
   .res_done      (res_done),
   .res_value     (res_value),
   .peak_val      (peak_val),
   .trough_val    (trough_val),
   .mode_q        (mode_q)
);

// File: tb/lvlstat_engine_test.sv
module lvlstat_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   // {mode[2:0], pattern[2:0], div[3:0]}
   localparam logic [9:0] VEC [NVEC] = '{
      {3'd0, 3'd2, 4'd3},   // R4 single
      {3'd1, 3'd6, 4'd0},   // R5 mean128 half truncation
      {3'd2, 3'd1, 4'd0},   // R5 mean1024 ramp
      {3'd2, 3'd0, 4'd1},   // R5 mean1024 full scale
      {3'd3, 3'd4, 4'd0},   // R6 spike
      {3'd4, 3'd5, 4'd0},   // R7 dip at window end
      {3'd4, 3'd0, 4'd0},   // R7 seed from first sample
      {3'd3, 3'd3, 4'd1},   // R6 all zero
      {3'd3, 3'd2, 4'd0},   // R6 permutation
      {3'd1, 3'd2, 4'd2}    // R5 mean128 mixed
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div_count = '0;
   logic        cmd_start = 1'b0;
   logic [2:0]  cmd_mode = '0;
   logic [9:0]  adc_sample;
   logic        sample_strobe, busy, res_done;
   logic [9:0]  res_value;

   int          tests = 0;
   int          fails = 0;
   int          cycles = 0;
   int          k = 0;
   logic [2:0]  pat = '0;

   lvlstat_engine uut (
      .clk(clk), .rst_n(rst_n), .div_count(div_count), .cmd_start(cmd_start),
      .cmd_mode(cmd_mode), .adc_sample(adc_sample), .sample_strobe(sample_strobe),
      .busy(busy), .res_value(res_value), .res_done(res_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [9:0] pat_val(input logic [2:0] p, input int idx);
      case (p)
         3'd0: return 10'd1023;
         3'd1: return 10'(idx % 1024);
         3'd2: return 10'((idx * 37 + 5) % 1024);
         3'd3: return 10'd0;
         3'd4: return (idx == 700) ? 10'd1000 : 10'd200;
         3'd5: return (idx == 1023) ? 10'd3 : 10'd900;
         3'd6: return (idx < 64) ? 10'd1023 : 10'd0;
         default: return 10'd0;
      endcase
   endfunction

   function automatic int mode_n(input logic [2:0] m);
      return (m == 3'd0) ? 1 : (m == 3'd1) ? 128 : 1024;
   endfunction

   function automatic int expect_val(input logic [2:0] m, input logic [2:0] p);
      int n = mode_n(m);
      int sum = 0;
      int mx = pat_val(p, 0);
      int mn = pat_val(p, 0);
      for (int i = 0; i < n; i++) begin
         int v = pat_val(p, i);
         sum += v;
         if (v > mx) mx = v;
         if (v < mn) mn = v;
      end
      case (m)
         3'd0: return sum;
         3'd1: return sum / 128;
         3'd2: return sum / 1024;
         3'd3: return mx;
         default: return mn;
      endcase
   endfunction

   always_comb adc_sample = pat_val(pat, k);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cmd_start && !busy) k <= 0;
      else if (sample_strobe)  k <= k + 1;
   end

   initial begin : watchdog
      wait (cycles > 150000);
      fails++;
      tests++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [2:0] m, input logic [2:0] p, input int dv);
      @(negedge clk);
      div_count = 16'(dv);
      cmd_mode  = m;
      pat       = p;
      cmd_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!res_done && n < 20000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      int strobes;
      logic [9:0] held;
      repeat (3) @(negedge clk);
      check("R1 done", res_done, 0);
      check("R1 busy", busy, 0);
      check("R1 strobe", sample_strobe, 0);
      check("R1 value", res_value, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         logic [2:0] m = VEC[v][9:7];
         logic [2:0] p = VEC[v][6:4];
         int dv = int'(VEC[v][3:0]);
         pulse_start(m, p, dv);
         check("R9 busy after start", busy, 1);
         wait_done(n);
         check("R10 completion edges", n, mode_n(m) * (dv + 1) + 1);
         check("R4-R7 result (R4 R5 R6 R7)", res_value, expect_val(m, p));
      end

      // R2 strobe spacing and div capture
      pulse_start(3'd1, 3'd6, 2);
      div_count = 16'd7;
      strobes = 0;
      n = 0;
      for (int c = 0; c < 9; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (sample_strobe) begin strobes++; n = c; end
      end
      check("R2 strobes in 9 cycles", strobes, 3);
      check("R2 last strobe position", n, 7);
      wait_done(n);
      check("R2 captured divider timing", n, 128 * 3 + 1 - 9);
      check("R2 result", res_value, 511);

      // R9 sticky done
      held = res_value;
      repeat (40) @(negedge clk);
      check("R9 done held", res_done, 1);
      check("R9 value held", res_value, held);

      // R3 illegal mode codes
      for (int bm = 5; bm < 8; bm++) begin
         pulse_start(3'(bm), 3'd0, 0);
         check("R3 illegal busy", busy, 0);
         check("R3 illegal done kept", res_done, 1);
         strobes = 0;
         repeat (10) begin
            @(negedge clk);
            if (sample_strobe) strobes++;
         end
         check("R3 illegal no strobe", strobes, 0);
      end

      // R8 start while busy ignored
      pulse_start(3'd2, 3'd1, 0);
      repeat (100) @(negedge clk);
      cmd_mode  = 3'd0;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      check("R8 busy kept", busy, 1);
      check("R8 done still low", res_done, 0);
      wait_done(n);
      check("R8 completion edges", n, 1025 - 101);
      check("R8 result unchanged", res_value, 511);

      // R1 reset mid-run
      pulse_start(3'd3, 3'd2, 1);
      repeat (50) @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 reset busy", busy, 0);
      check("R1 reset done", res_done, 0);
      check("R1 reset value", res_value, 0);
      rst_n = 1'b1;
      pulse_start(3'd0, 3'd2, 0);
      wait_done(n);
      check("R4 after reset edges", n, 2);
      check("R4 after reset value", res_value, 5);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule